// File: doc/BRIEF.md
# ACPI Sleep and Reset Control

This block holds the fixed-hardware control registers that an operating system uses to reset or switch off a platform. It sits on a simple I/O-port bus. The bus has an address, an access size, read and write strobes, write data, read data and an error flag. Read data and the error flag are combinational and valid in the same cycle as the strobe. Three locations are decoded. The first is a one-byte reset control register. The second is a 16-bit sleep control word. The third is a write-only command port that turns the interrupt-routing enable on and off.

The block issues three things to the rest of the chip. A system-reset request and a power-off request are each a one-clock pulse in the cycle after the write that triggers it. The third is the present level of the interrupt-routing enable bit. A direct write to the sleep control word never changes that bit. Bits that are reserved, and bits that only trigger an action, are never kept in stored state.

Top module: `acpi_fixed_ctl`

## Requirements
- R1: After the active-low reset, the reset control byte, the sleep control word and the interrupt-routing enable are all zero, and neither request output is high.
- R2: A 1-byte access (bus_size = 0) at the reset control address stores bits 7:0 of the write data. A 1-byte read there returns the last stored byte, zero-extended.
- R3: A write to the reset control register with bit 2 set makes sys_reset_req high for exactly the one cycle after the write. Bit 1 is stored but has no effect. A write with bit 2 clear raises no request.
- R4: A 2-byte write (bus_size = 1) to the sleep control address stores write data bits 12:2 and reads bits 15:13 and 1 back as zero. Bit 0 reads back as the interrupt-routing enable, whatever was written to it.
- R5: A sleep control write with bit 13 set and bits 12:10 equal to 5 makes power_off_req high for exactly the one cycle after the write. Any other combination raises no request.
- R6: An access of the wrong size sets bus_err in that cycle. Wrong sizes are any size other than 1 byte at the reset and command ports, and any size other than 2 bytes at the sleep control word. Such an access changes no state and no output, and a read of this kind returns zero.
- R7: A 1-byte write of the enable code (parameter, default 0xA0) to the command port sets the interrupt-routing enable. A write of the disable code (default 0xA1) clears it. Every other code leaves it unchanged. The new level appears on sci_en and as bit 0 of the sleep control word from the next cycle onward.
- R8: A read of the command port returns zero and sets bus_err.
- R9: An access to any other address returns zero, leaves bus_err low and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | I/O port address |
| bus_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| bus_err | output | 1 | Access rejected in this cycle |
| sys_reset_req | output | 1 | One-cycle system-reset request |
| power_off_req | output | 1 | One-cycle power-off request |
| sci_en | output | 1 | Interrupt-routing enable level |

## Verification
A command-port write changes the enable bit at a clock edge. A sleep control write, which must keep that bit, can arrive in the very next cycle. The bench drives an enable command and then a sleep word with bit 0 clear back to back. It judges the pair by reading bit 0 back as one and by seeing sci_en still high. A second case puts a reset-triggering write directly before a power-off write. The bench then checks that the reset pulse appears while the second write is accepted, and that each pulse lasts one cycle on its own edge.

// File: rtl/acpi_ctl_pkg.sv
package acpi_ctl_pkg;

  typedef enum logic [1:0] {
    SZ_B1   = 2'd0,
    SZ_B2   = 2'd1,
    SZ_B4   = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int CTL_W       = 16;
  localparam int RSTC_W      = 8;
  localparam int RST_GO_BIT  = 2;
  localparam int SLP_EN_BIT  = 13;
  localparam int SLP_TYP_LO  = 10;
  localparam int SLP_TYP_W   = 3;

  localparam logic [SLP_TYP_W-1:0] SLP_TYP_OFF    = 3'd5;
  localparam logic [CTL_W-1:0]     PM1_STORE_MASK = 16'h1FFC;

endpackage

// File: rtl/acpi_rst_ctl.sv
module acpi_rst_ctl
  import acpi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RSTC_W-1:0] wdata,
  output logic [RSTC_W-1:0] byte_q,
  output logic              reset_req
);

  logic [RSTC_W-1:0] byte_d;
  logic              req_d;

  always_comb begin
    byte_d = byte_q;
    req_d  = 1'b0;
    if (wr_en) begin
      byte_d = wdata;
      req_d  = wdata[RST_GO_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q    <= '0;
      reset_req <= 1'b0;
    end else begin
      byte_q    <= byte_d;
      reset_req <= req_d;
    end
  end

  assert_rst_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[RST_GO_BIT]) |=> reset_req);

  assert_rst_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !reset_req);

  assert_byte_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(byte_q));

endmodule

// File: rtl/acpi_pm1_ctl.sv
module acpi_pm1_ctl
  import acpi_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  input  logic             sci_set,
  input  logic             sci_clr,
  output logic [CTL_W-1:0] ctl_q,
  output logic             sci_en,
  output logic             off_req
);

  logic [CTL_W-1:1] body_q, body_d;
  logic             sci_q, sci_d;
  logic             off_d;
  logic [CTL_W-1:0] wmask;

  assign wmask = wdata & PM1_STORE_MASK;

  always_comb begin
    body_d = body_q;
    if (wr_en) body_d = wmask[CTL_W-1:1];
  end

  always_comb begin
    sci_d = sci_q;
    if (sci_set)      sci_d = 1'b1;
    else if (sci_clr) sci_d = 1'b0;
  end

  always_comb begin
    off_d = wr_en && wdata[SLP_EN_BIT] &&
            (wdata[SLP_TYP_LO +: SLP_TYP_W] == SLP_TYP_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      body_q  <= '0;
      sci_q   <= 1'b0;
      off_req <= 1'b0;
    end else begin
      body_q  <= body_d;
      sci_q   <= sci_d;
      off_req <= off_d;
    end
  end

  assign ctl_q  = {body_q, sci_q};
  assign sci_en = sci_q;

  assert_sci_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sci_set && !sci_clr) |=> $stable(sci_en));

  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[15:13] == 3'b000) && !ctl_q[1]);

  assert_off_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |-> $past(wr_en));

  assert_sci_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sci_set |=> sci_en);

  assert_sci_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_clr && !sci_set) |=> !sci_en);

endmodule

// File: rtl/acpi_smi_dec.sv
module acpi_smi_dec #(
  parameter logic [7:0] CMD_ON  = 8'hA0,
  parameter logic [7:0] CMD_OFF = 8'hA1
) (
  input  logic       wr_en,
  input  logic [7:0] code,
  output logic       sci_set,
  output logic       sci_clr
);

  always_comb begin
    sci_set = wr_en && (code == CMD_ON);
    sci_clr = wr_en && (code == CMD_OFF);
  end

endmodule

// File: rtl/acpi_fixed_ctl.sv
module acpi_fixed_ctl
  import acpi_ctl_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         DATA_W   = 32,
  parameter logic [15:0] RST_ADDR = 16'h0CF9,
  parameter logic [15:0] PM1_ADDR = 16'h0404,
  parameter logic [15:0] SMI_ADDR = 16'h00B2,
  parameter logic [7:0]  CMD_ON   = 8'hA0,
  parameter logic [7:0]  CMD_OFF  = 8'hA1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              sys_reset_req,
  output logic              power_off_req,
  output logic              sci_en
);

  localparam int PAD_RST = DATA_W - RSTC_W;
  localparam int PAD_PM1 = DATA_W - CTL_W;

  logic sel_rst, sel_pm1, sel_smi;
  logic ok_rst, ok_pm1, ok_smi;
  logic wr_rst, wr_pm1, wr_smi;
  logic rd_rst, rd_pm1;
  logic sci_set, sci_clr;
  logic [RSTC_W-1:0] rst_byte;
  logic [CTL_W-1:0]  pm1_word;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CTL_W];

  always_comb begin
    sel_rst = (bus_addr == ADDR_W'(RST_ADDR));
    sel_pm1 = (bus_addr == ADDR_W'(PM1_ADDR));
    sel_smi = (bus_addr == ADDR_W'(SMI_ADDR));
    ok_rst  = (bus_size == SZ_B1);
    ok_pm1  = (bus_size == SZ_B2);
    ok_smi  = (bus_size == SZ_B1);
    wr_rst  = bus_wr && sel_rst && ok_rst;
    wr_pm1  = bus_wr && sel_pm1 && ok_pm1;
    wr_smi  = bus_wr && sel_smi && ok_smi;
    rd_rst  = bus_rd && sel_rst && ok_rst;
    rd_pm1  = bus_rd && sel_pm1 && ok_pm1;
  end

  always_comb begin
    bus_err = 1'b0;
    if (bus_rd || bus_wr) begin
      bus_err = (sel_rst && !ok_rst) ||
                (sel_pm1 && !ok_pm1) ||
                (sel_smi && (bus_rd || !ok_smi));
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_rst)      bus_rdata = {{PAD_RST{1'b0}}, rst_byte};
    else if (rd_pm1) bus_rdata = {{PAD_PM1{1'b0}}, pm1_word};
  end

  acpi_rst_ctl u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_rst),
    .wdata     (bus_wdata[RSTC_W-1:0]),
    .byte_q    (rst_byte),
    .reset_req (sys_reset_req)
  );

  acpi_smi_dec #(
    .CMD_ON  (CMD_ON),
    .CMD_OFF (CMD_OFF)
  ) u_smi (
    .wr_en   (wr_smi),
    .code    (bus_wdata[7:0]),
    .sci_set (sci_set),
    .sci_clr (sci_clr)
  );

  acpi_pm1_ctl u_pm1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_pm1),
    .wdata   (bus_wdata[CTL_W-1:0]),
    .sci_set (sci_set),
    .sci_clr (sci_clr),
    .ctl_q   (pm1_word),
    .sci_en  (sci_en),
    .off_req (power_off_req)
  );

  assert_smi_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_smi) |-> (bus_err && bus_rdata == '0));

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !sel_rst && !sel_pm1 && !sel_smi) |->
      (!bus_err && bus_rdata == '0));

  assert_bad_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_pm1 && !ok_pm1) |=> ($stable(pm1_word) && !power_off_req));

endmodule

// File: tb/test_acpi_fixed_ctl.sv
module test_acpi_fixed_ctl;

  localparam logic [15:0] A_RST = 16'h0CF9;
  localparam logic [15:0] A_PM1 = 16'h0404;
  localparam logic [15:0] A_SMI = 16'h00B2;
  localparam logic [15:0] A_NIL = 16'h0080;
  localparam logic [7:0]  C_ON  = 8'hA0;
  localparam logic [7:0]  C_OFF = 8'hA1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err, sys_reset_req, power_off_req, sci_en;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  acpi_fixed_ctl i_acpi_fixed_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_size      (bus_size),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_err       (bus_err),
    .sys_reset_req (sys_reset_req),
    .power_off_req (power_off_req),
    .sci_en        (sci_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d,
                       output logic e, output logic rp, output logic op);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    #1 e = bus_err;
    @(negedge clk);
    rp = sys_reset_req; op = power_off_req;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_rd(input logic [15:0] a, input logic [1:0] sz,
                       output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    #1 d = bus_rdata; e = bus_err;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle_low(input string req);
    @(negedge clk);
    chk(!sys_reset_req && !power_off_req, req, {sys_reset_req, power_off_req}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic e, rp, op;
    logic [31:0] d;
    logic exp_sci;
    logic [15:0] exp_pm1;
    logic [7:0]  exp_rst;

    rst_n = 1'b0; bus_addr = '0; bus_size = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk(!sys_reset_req && !power_off_req && !sci_en, "R1 outputs",
        {sys_reset_req, power_off_req, sci_en}, 0);
    do_rd(A_RST, 2'd0, d, e); chk(d == 0, "R1 reset byte", d, 0);
    do_rd(A_PM1, 2'd1, d, e); chk(d == 0, "R1 sleep word", d, 0);
    exp_sci = 1'b0;

    // R2 / R3 full byte sweep
    for (int v = 0; v < 256; v++) begin
      do_wr(A_RST, 2'd0, 32'(v), e, rp, op);
      chk(e == 0, "R2 no err", e, 0);
      chk(rp == v[2], "R3 pulse", rp, v[2]);
      idle_low("R3 single cycle");
      do_rd(A_RST, 2'd0, d, e);
      chk(d == 32'(v), "R2 readback", d, v);
    end
    exp_rst = 8'hFF;

    // R4 / R5 sleep word sweep, enable off
    for (int v = 0; v < 65536; v += 37) begin
      do_wr(A_PM1, 2'd1, {16'hFFFF, 16'(v)}, e, rp, op);
      exp_pm1 = (16'(v) & 16'h1FFC) | {15'b0, exp_sci};
      chk(op == (v[13] && v[12:10] == 3'd5), "R5 sweep pulse", op, 0);
      do_rd(A_PM1, 2'd1, d, e);
      chk(d == {16'b0, exp_pm1}, "R4 sweep readback", d, exp_pm1);
    end
    // R5 all sleep types with and without the trigger bit
    for (int t = 0; t < 8; t++) begin
      for (int en = 0; en < 2; en++) begin
        d = 32'((en << 13) | (t << 10) | 1);
        do_wr(A_PM1, 2'd1, d, e, rp, op);
        chk(op == (en == 1 && t == 5), "R5 type pulse", op, (en == 1 && t == 5));
        idle_low("R5 single cycle");
      end
    end

    // R7 command sweep over every code
    for (int c = 0; c < 256; c++) begin
      do_wr(A_SMI, 2'd0, 32'(c), e, rp, op);
      if (8'(c) == C_ON) exp_sci = 1'b1;
      else if (8'(c) == C_OFF) exp_sci = 1'b0;
      chk(sci_en == exp_sci && e == 0, "R7 code", sci_en, exp_sci);
    end
    do_wr(A_SMI, 2'd0, 32'(C_ON), e, rp, op); exp_sci = 1'b1;
    do_wr(A_SMI, 2'd0, 32'h55, e, rp, op);
    chk(sci_en == 1'b1, "R7 other code ignored", sci_en, 1);
    do_rd(A_PM1, 2'd1, d, e);
    chk(d[0] == 1'b1, "R7 bit0 mirrors enable", d[0], 1);
    do_wr(A_SMI, 2'd0, 32'(C_OFF), e, rp, op); exp_sci = 1'b0;
    do_wr(A_PM1, 2'd1, 32'h0001, e, rp, op);
    do_rd(A_PM1, 2'd1, d, e);
    chk(d == 0 && !sci_en, "R4 bit0 not writable", d, 0);

    // set known state for R6/R9
    do_wr(A_RST, 2'd0, 32'h5A, e, rp, op); exp_rst = 8'h5A;
    do_wr(A_PM1, 2'd1, 32'h0C30, e, rp, op); exp_pm1 = 16'h0C30;

    // R6 wrong sizes
    for (int s = 0; s < 4; s++) begin
      if (s != 0) begin
        do_wr(A_RST, 2'(s), 32'hFFFF_FFFF, e, rp, op);
        chk(e && !rp, "R6 rst bad write", {e, rp}, 2);
        do_rd(A_RST, 2'(s), d, e);
        chk(e && d == 0, "R6 rst bad read", d, 0);
        do_wr(A_SMI, 2'(s), 32'(C_ON), e, rp, op);
        chk(e && !sci_en, "R6 cmd bad size", {e, sci_en}, 2);
      end
      if (s != 1) begin
        do_wr(A_PM1, 2'(s), 32'h0000_3400, e, rp, op);
        chk(e && !op, "R6 sleep bad write", {e, op}, 2);
        do_rd(A_PM1, 2'(s), d, e);
        chk(e && d == 0, "R6 sleep bad read", d, 0);
      end
    end
    do_rd(A_RST, 2'd0, d, e); chk(d == 32'(exp_rst), "R6 rst unchanged", d, exp_rst);
    do_rd(A_PM1, 2'd1, d, e); chk(d == 32'(exp_pm1), "R6 sleep unchanged", d, exp_pm1);

    // R8 command port read
    do_rd(A_SMI, 2'd0, d, e);
    chk(e && d == 0, "R8 read of command port", {d[30:0], e}, 1);

    // R9 unmapped
    for (int s = 0; s < 4; s++) begin
      do_wr(A_NIL, 2'(s), 32'hFFFF_FFFF, e, rp, op);
      chk(!e && !rp && !op, "R9 unmapped write", {e, rp, op}, 0);
      do_rd(A_NIL, 2'(s), d, e);
      chk(!e && d == 0, "R9 unmapped read", d, 0);
    end
    do_rd(A_RST, 2'd0, d, e); chk(d == 32'(exp_rst), "R9 rst unchanged", d, exp_rst);
    do_rd(A_PM1, 2'd1, d, e); chk(d == 32'(exp_pm1), "R9 sleep unchanged", d, exp_pm1);

    // R4 / R7 back to back: enable command then sleep write clearing bit 0
    @(negedge clk);
    bus_addr = A_SMI; bus_size = 2'd0; bus_wdata = 32'(C_ON); bus_wr = 1'b1;
    @(negedge clk);
    bus_addr = A_PM1; bus_size = 2'd1; bus_wdata = 32'h0000_0800;
    @(negedge clk);
    bus_wr = 1'b0;
    chk(sci_en, "R7 enable survives next write", sci_en, 1);
    do_rd(A_PM1, 2'd1, d, e);
    chk(d == 32'h0801, "R4 back-to-back readback", d, 32'h0801);

    // R3 / R5 back to back: reset write then power-off write
    @(negedge clk);
    bus_addr = A_RST; bus_size = 2'd0; bus_wdata = 32'h06; bus_wr = 1'b1;
    @(negedge clk);
    chk(sys_reset_req && !power_off_req, "R3 pulse during next write",
        {sys_reset_req, power_off_req}, 2);
    bus_addr = A_PM1; bus_size = 2'd1; bus_wdata = 32'h0000_3400;
    @(negedge clk);
    bus_wr = 1'b0;
    chk(!sys_reset_req && power_off_req, "R5 pulse after reset pulse",
        {sys_reset_req, power_off_req}, 1);
    idle_low("R5 back-to-back single cycle");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule